// File: doc/BRIEF.md
# Package Dispatch Test Controller

This block sequences test data packages from one test source over a shared bus to a set of per-core buffers. A schedule table holds an ordered list of entries. Each entry names a destination core and the earliest cycle, counted from the start of dispatch, at which that package may go out. The controller works through the list one entry at a time. When an entry is released, it raises that core's notify line and holds it until the core pulses its taken line. It then moves to the next entry. Only one package is ever on the bus, but the interleaving lets several cores apply their tests at the same time.

The schedule is written before a run through a valid/ready load stream. Entries are accepted only while the controller is idle and the table has room. An accepted entry whose core index is out of range is consumed and discarded. A one-cycle `go` pulse starts dispatch. The run ends in one of two sticky conditions: done, after the last entry is taken, or fault, after a stray taken pulse or a missing one. A further `go` pulse clears the condition and empties the table for the next schedule.

Load-stream back-pressure works as follows. A beat transfers on a cycle where `ld_valid_i` and `ld_ready_o` are both high. `ld_ready_o` is low whenever dispatch is active or finished, and whenever the table is full. A source may hold a beat for any length of time while ready is low; that beat is neither stored nor dropped.

Top module: `pkt_dispatch_ctrl`

## Requirements
- R1: After reset, all notify lines, `done_o` and `fault_o` are low, `ld_ready_o` is high and the table is empty.
- R2: `ld_ready_o` is high only when idle with fewer than DEPTH entries stored. Entries are stored in arrival order, and a held beat is not taken while ready is low.
- R3: A `go` pulse while idle with at least one entry starts dispatch and zeroes the send-time counter. A `go` pulse with an empty table has no effect.
- R4: The send-time counter reads 0 in the first cycle after the starting `go` and counts up by one each cycle. An entry's notify line cannot rise before the cycle in which the counter equals its send time plus one.
- R5: While an entry waits for its taken pulse, exactly the notify bit at position = the entry's core index is high. At all other times every notify bit is low.
- R6: A taken pulse from the notified core ends the announcement. In the next cycle every notify line is low, so consecutive packages, even to the same core, are separated by at least one quiet cycle.
- R7: Entries are dispatched strictly in table order, one at a time.
- R8: Any taken pulse from a core other than the notified one, or any taken pulse while no core is notified during dispatch, sets `fault_o` and stops dispatch with all notify lines low.
- R9: If the notified core gives no taken pulse within `ack_limit_i` cycles of notify being high, the controller faults. A limit of 0 behaves as 1.
- R10: `done_o` rises in the cycle after the last entry's taken pulse, and the notify lines stay low from then on.
- R11: `done_o` and `fault_o` are sticky until a `go` pulse. That pulse returns the block to idle with the table empty and `ld_ready_o` high.
- R12: A loaded entry with a core index of N_CORES or more is accepted on the stream but never stored or dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | Schedule load beat valid |
| ld_ready_o | output | 1 | Schedule load beat ready |
| ld_core_i | input | CORE_W | Destination core index of the beat |
| ld_time_i | input | TIME_W | Earliest send cycle of the beat |
| go_i | input | 1 | Start dispatch, or clear a finished run |
| ack_limit_i | input | TO_W | Cycles allowed for a taken pulse |
| taken_i | input | N_CORES | Per-core package-taken pulse |
| notify_o | output | N_CORES | Per-core package-coming line |
| done_o | output | 1 | Schedule completed (sticky) |
| fault_o | output | 1 | Handshake fault (sticky) |

## Verification
The properties assume well-behaved inputs:
- `go_i` and each taken bit are single-cycle pulses.
- A core answers only its own announcement.
- The reset is held for at least one edge.

The bench's responder pulses a taken bit exactly once per rising notify, after a chosen latency, and then drops it. Stray pulses, wrong-core answers and silence are injected only in dedicated phases, each of which ends in the fault state and is cleared with `go` before the next phase. Load beats may be held while ready is low. The reference model applies the same valid-and-ready transfer rule.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    PD_IDLE  = 3'd0,
    PD_HOLD  = 3'd1,
    PD_SEND  = 3'd2,
    PD_DONE  = 3'd3,
    PD_FAULT = 3'd4
  } pd_state_e;
endpackage

// File: rtl/pdc_sched_table.sv
module pdc_sched_table #(
  parameter int N_CORES = 3,
  parameter int DEPTH   = 8,
  parameter int TIME_W  = 16,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              clear,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [CORE_W-1:0] ld_core,
  input  logic [TIME_W-1:0] ld_time,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CORE_W-1:0] rd_core,
  output logic [TIME_W-1:0] rd_time,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CORE_W:0]   CORE_LIM = (CORE_W + 1)'(N_CORES);

  logic              beat;
  logic              core_ok;
  logic              wr_en;
  logic [CORE_W-1:0] core_arr [DEPTH];
  logic [TIME_W-1:0] time_arr [DEPTH];

  assign ld_ready = load_en && (count != FULL_CNT);
  assign beat     = ld_valid && ld_ready;
  assign core_ok  = {1'b0, ld_core} < CORE_LIM;
  assign wr_en    = beat && core_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (wr_en)   count <= count + 1'b1;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    logic [CORE_W-1:0] core_r;
    logic [TIME_W-1:0] time_r;
    always_ff @(posedge clk) begin
      if (wr_en && (count == CNT_W'(e))) begin
        core_r <= ld_core;
        time_r <= ld_time;
      end
    end
    assign core_arr[e] = core_r;
    assign time_arr[e] = time_r;
  end

  assign rd_core = core_arr[rd_idx];
  assign rd_time = time_arr[rd_idx];
endmodule

// File: rtl/pdc_timers.sv
module pdc_timers #(
  parameter int TIME_W = 16,
  parameter int TO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_clr,
  input  logic              tmr_run,
  input  logic              wd_clr,
  input  logic              wd_run,
  input  logic [TO_W-1:0]   ack_limit,
  output logic [TIME_W-1:0] tmr,
  output logic              wd_expire
);
  logic [TO_W-1:0] wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tmr <= '0;
    else if (tmr_clr)            tmr <= '0;
    else if (tmr_run && !(&tmr)) tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wd <= '0;
    else if (wd_clr)           wd <= '0;
    else if (wd_run && !(&wd)) wd <= wd + 1'b1;
  end

  assign wd_expire = ({1'b0, wd} + 1'b1) >= {1'b0, ack_limit};
endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
  import pdc_pkg::*;
#(
  parameter int N_CORES = 3,
  parameter int DEPTH   = 8,
  parameter int TIME_W  = 16,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [N_CORES-1:0] taken,
  input  logic [N_CORES-1:0] sel,
  input  logic [CNT_W-1:0]   count,
  input  logic [TIME_W-1:0]  rd_time,
  input  logic [TIME_W-1:0]  tmr,
  input  logic               wd_expire,
  output pd_state_e          state,
  output logic [IDX_W-1:0]   idx,
  output logic               tmr_clr,
  output logic               tmr_run,
  output logic               wd_clr,
  output logic               wd_run,
  output logic               tbl_clear,
  output logic               load_en
);
  pd_state_e        nxt;
  logic [IDX_W-1:0] idx_nxt;
  logic             is_last;
  logic             ack;
  logic             stray;

  assign is_last = ({1'b0, idx} + 1'b1) == (IDX_W + 1)'(count);
  assign ack     = |(taken & sel);
  assign stray   = |(taken & ~sel);

  always_comb begin
    nxt       = state;
    idx_nxt   = idx;
    tmr_clr   = 1'b0;
    wd_clr    = 1'b0;
    tbl_clear = 1'b0;
    unique case (state)
      PD_IDLE: begin
        if (go && (count != '0)) begin
          nxt     = PD_HOLD;
          idx_nxt = '0;
          tmr_clr = 1'b1;
        end
      end
      PD_HOLD: begin
        if (|taken) begin
          nxt = PD_FAULT;
        end else if (tmr >= rd_time) begin
          nxt    = PD_SEND;
          wd_clr = 1'b1;
        end
      end
      PD_SEND: begin
        if (stray) begin
          nxt = PD_FAULT;
        end else if (ack) begin
          if (is_last) begin
            nxt = PD_DONE;
          end else begin
            nxt     = PD_HOLD;
            idx_nxt = idx + 1'b1;
          end
        end else if (wd_expire) begin
          nxt = PD_FAULT;
        end
      end
      PD_DONE, PD_FAULT: begin
        if (go) begin
          nxt       = PD_IDLE;
          tbl_clear = 1'b1;
        end
      end
      default: nxt = PD_FAULT;
    endcase
  end

  assign tmr_run = (state == PD_HOLD) || (state == PD_SEND);
  assign wd_run  = (state == PD_SEND);
  assign load_en = (state == PD_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PD_IDLE;
      idx   <= '0;
    end else begin
      state <= nxt;
      idx   <= idx_nxt;
    end
  end
endmodule

// File: rtl/pkt_dispatch_ctrl.sv
module pkt_dispatch_ctrl
  import pdc_pkg::*;
#(
  parameter int N_CORES = 3,
  parameter int DEPTH   = 8,
  parameter int TIME_W  = 16,
  parameter int TO_W    = 8,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid_i,
  output logic               ld_ready_o,
  input  logic [CORE_W-1:0]  ld_core_i,
  input  logic [TIME_W-1:0]  ld_time_i,
  input  logic               go_i,
  input  logic [TO_W-1:0]    ack_limit_i,
  input  logic [N_CORES-1:0] taken_i,
  output logic [N_CORES-1:0] notify_o,
  output logic               done_o,
  output logic               fault_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  pd_state_e          state;
  logic [IDX_W-1:0]   idx;
  logic [CORE_W-1:0]  rd_core;
  logic [TIME_W-1:0]  rd_time;
  logic [CNT_W-1:0]   count;
  logic [TIME_W-1:0]  tmr;
  logic               wd_expire;
  logic               tmr_clr, tmr_run, wd_clr, wd_run, tbl_clear, load_en;
  logic [N_CORES-1:0] sel;

  pdc_sched_table #(.N_CORES(N_CORES), .DEPTH(DEPTH), .TIME_W(TIME_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .clear    (tbl_clear),
    .ld_valid (ld_valid_i),
    .ld_ready (ld_ready_o),
    .ld_core  (ld_core_i),
    .ld_time  (ld_time_i),
    .rd_idx   (idx),
    .rd_core  (rd_core),
    .rd_time  (rd_time),
    .count    (count)
  );

  pdc_timers #(.TIME_W(TIME_W), .TO_W(TO_W)) u_timers (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_clr   (tmr_clr),
    .tmr_run   (tmr_run),
    .wd_clr    (wd_clr),
    .wd_run    (wd_run),
    .ack_limit (ack_limit_i),
    .tmr       (tmr),
    .wd_expire (wd_expire)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_sel
    assign sel[c] = (rd_core == CORE_W'(c));
  end

  pdc_fsm #(.N_CORES(N_CORES), .DEPTH(DEPTH), .TIME_W(TIME_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_i),
    .taken     (taken_i),
    .sel       (sel),
    .count     (count),
    .rd_time   (rd_time),
    .tmr       (tmr),
    .wd_expire (wd_expire),
    .state     (state),
    .idx       (idx),
    .tmr_clr   (tmr_clr),
    .tmr_run   (tmr_run),
    .wd_clr    (wd_clr),
    .wd_run    (wd_run),
    .tbl_clear (tbl_clear),
    .load_en   (load_en)
  );

  assign notify_o = (state == PD_SEND) ? sel : '0;
  assign done_o   = (state == PD_DONE);
  assign fault_o  = (state == PD_FAULT);
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int N_CORES = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               go_i,
  input logic               ld_ready_o,
  input logic [N_CORES-1:0] taken_i,
  input logic [N_CORES-1:0] notify_o,
  input logic               done_o,
  input logic               fault_o
);
  // R5
  notify_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(notify_o));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(notify_o & taken_i)) |=> (notify_o == '0));

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !go_i) |=> done_o);

  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !go_i) |=> fault_o);

  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (notify_o == '0 && !done_o && !ld_ready_o));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready_o |-> (notify_o == '0 && !done_o && !fault_o));
endmodule

bind pkt_dispatch_ctrl pdc_checker #(.N_CORES(N_CORES)) u_pdc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .go_i       (go_i),
  .ld_ready_o (ld_ready_o),
  .taken_i    (taken_i),
  .notify_o   (notify_o),
  .done_o     (done_o),
  .fault_o    (fault_o)
);

// File: tb/test_pkt_dispatch_ctrl.sv
module test_pkt_dispatch_ctrl;
  localparam int NC = 3;
  localparam int DEPTH = 8;
  localparam int TW = 16;
  localparam int OW = 8;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid_i = 1'b0;
  logic ld_ready_o;
  logic [CW-1:0] ld_core_i = '0;
  logic [TW-1:0] ld_time_i = '0;
  logic go_i = 1'b0;
  logic [OW-1:0] ack_limit_i = 8'd20;
  logic [NC-1:0] taken_i = '0;
  logic [NC-1:0] notify_o;
  logic done_o, fault_o;

  int vectors = 0;
  int miscompares = 0;
  int since = 0;
  int last_high = 0;
  int exp_core[$];
  int exp_time[$];
  int got_core[$];

  // behavioural reference state
  int m_st = 0;
  int m_idx = 0;
  int m_tmr = 0;
  int m_wd = 0;
  int q_core[$];
  int q_time[$];

  always #10 clk = ~clk;

  pkt_dispatch_ctrl #(.N_CORES(NC), .DEPTH(DEPTH), .TIME_W(TW), .TO_W(OW)) i_pkt_dispatch_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_valid_i(ld_valid_i), .ld_ready_o(ld_ready_o),
    .ld_core_i(ld_core_i), .ld_time_i(ld_time_i), .go_i(go_i), .ack_limit_i(ack_limit_i),
    .taken_i(taken_i), .notify_o(notify_o), .done_o(done_o), .fault_o(fault_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_step();
    bit rdy;
    logic [NC-1:0] sel;
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_tmr = 0; m_wd = 0;
      q_core.delete(); q_time.delete();
      return;
    end
    rdy = (m_st == 0) && (q_core.size() < DEPTH);
    case (m_st)
      0: begin
        if (go_i && q_core.size() > 0) begin
          m_st = 1; m_idx = 0; m_tmr = 0;
        end
        if (ld_valid_i && rdy && int'(ld_core_i) < NC) begin
          q_core.push_back(int'(ld_core_i));
          q_time.push_back(int'(ld_time_i));
        end
      end
      1: begin
        if (taken_i != '0) m_st = 4;
        else if (m_tmr >= q_time[m_idx]) begin m_st = 2; m_wd = 0; end
        if (m_tmr < 65535) m_tmr++;
      end
      2: begin
        sel = NC'(1 << q_core[m_idx]);
        if ((taken_i & ~sel) != '0) m_st = 4;
        else if ((taken_i & sel) != '0) begin
          if (m_idx == q_core.size() - 1) m_st = 3;
          else begin m_idx++; m_st = 1; end
        end else if (m_wd + 1 >= int'(ack_limit_i)) m_st = 4;
        else m_wd++;
        if (m_tmr < 65535) m_tmr++;
      end
      default: begin
        if (go_i) begin
          m_st = 0; q_core.delete(); q_time.delete();
        end
      end
    endcase
  endfunction

  task automatic compare();
    logic [NC-1:0] es;
    es = (m_st == 2) ? NC'(1 << q_core[m_idx]) : '0;
    vectors++;
    if (notify_o !== es) begin
      miscompares++;
      $display("FAIL R5 notify actual=%0d expected=%0d", notify_o, es);
    end
    if (done_o !== (m_st == 3)) begin
      miscompares++;
      $display("FAIL R10 done actual=%0d expected=%0d", done_o, m_st == 3);
    end
    if (fault_o !== (m_st == 4)) begin
      miscompares++;
      $display("FAIL R8 fault actual=%0d expected=%0d", fault_o, m_st == 4);
    end
    if (ld_ready_o !== ((m_st == 0) && (q_core.size() < DEPTH))) begin
      miscompares++;
      $display("FAIL R2 ready actual=%0d expected=%0d", ld_ready_o,
               (m_st == 0) && (q_core.size() < DEPTH));
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic load(input int core, input int t);
    ld_valid_i = 1'b1;
    ld_core_i = CW'(core);
    ld_time_i = TW'(t);
    cyc();
    ld_valid_i = 1'b0;
  endtask

  task automatic pulse_go();
    go_i = 1'b1;
    cyc();
    go_i = 1'b0;
    since = 0;
  endtask

  // mode 0: correct core answers; mode 1: neighbour core answers
  task automatic run(input int lat, input int mode, input int maxc);
    int cnt = 0;
    int k = 0;
    int high = 0;
    bit acked = 1'b0;
    logic [NC-1:0] prev = '0;
    got_core.delete();
    for (int c = 0; c < maxc; c++) begin
      if (acked) begin
        chk(notify_o == '0, "R6", int'(notify_o), 0);
        acked = 1'b0;
      end
      if (notify_o != '0) high++;
      if (notify_o != '0 && prev == '0) begin
        chk($countones(notify_o) == 1, "R5", $countones(notify_o), 1);
        if (k < exp_time.size())
          chk(since >= exp_time[k] + 1, "R4", since, exp_time[k] + 1);
      end
      prev = notify_o;
      taken_i = '0;
      if (notify_o != '0) begin
        if (cnt == lat) begin
          if (mode == 0) begin
            taken_i = notify_o;
            for (int b = 0; b < NC; b++) if (notify_o[b]) got_core.push_back(b);
            k++;
            acked = 1'b1;
          end else begin
            taken_i = {notify_o[NC-2:0], notify_o[NC-1]};
          end
          cnt = 0;
        end else cnt++;
      end else cnt = 0;
      cyc();
      since++;
      if (done_o || fault_o) break;
    end
    taken_i = '0;
    last_high = high;
  endtask

  task automatic check_order(input string req);
    chk(got_core.size() == exp_core.size(), req, got_core.size(), exp_core.size());
    for (int i = 0; i < exp_core.size() && i < got_core.size(); i++)
      chk(got_core[i] == exp_core[i], req, got_core[i], exp_core[i]);
  endtask

  initial begin
    int lim = 150000;
    repeat (lim) @(posedge clk);
    miscompares++;
    $display("FAIL R10 watchdog expired actual=%0d expected=0", lim);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk(notify_o == '0 && !done_o && !fault_o, "R1", int'(notify_o), 0);
    chk(ld_ready_o == 1'b1, "R1", ld_ready_o, 1);

    // R3: go with empty table has no effect
    pulse_go();
    cyc();
    chk(ld_ready_o == 1'b1 && notify_o == '0 && !done_o, "R3", ld_ready_o, 1);

    // full schedule: 3/2/3 packages across three cores, staggered times
    exp_core = '{0, 1, 2, 0, 1, 2, 0, 2};
    exp_time = '{0, 2, 4, 10, 12, 14, 30, 32};
    foreach (exp_core[i]) load(exp_core[i], exp_time[i]);
    // R2 table full
    chk(ld_ready_o == 1'b0, "R2", ld_ready_o, 0);
    load(1, 50);
    ack_limit_i = 8'd20;
    pulse_go();
    run(3, 0, 400);
    // R10
    chk(done_o == 1'b1 && notify_o == '0, "R10", done_o, 1);
    // R7
    check_order("R7");
    repeat (3) cyc();
    chk(done_o == 1'b1, "R11", done_o, 1);
    pulse_go();
    // R11 clear
    chk(ld_ready_o == 1'b1 && !done_o, "R11", ld_ready_o, 1);

    // merged group to one core plus an out-of-range entry (R12)
    exp_core = '{1, 1, 1};
    exp_time = '{0, 0, 0};
    load(1, 0); load(1, 0); load(3, 0); load(1, 0);
    pulse_go();
    run(0, 0, 100);
    chk(done_o == 1'b1, "R10", done_o, 1);
    check_order("R12");
    pulse_go();

    // wrong core answers (R8)
    exp_core = '{0, 2};
    exp_time = '{0, 0};
    load(0, 0); load(2, 0);
    pulse_go();
    run(1, 1, 100);
    chk(fault_o == 1'b1 && notify_o == '0, "R8", fault_o, 1);
    repeat (2) cyc();
    chk(fault_o == 1'b1, "R11", fault_o, 1);
    pulse_go();

    // stray pulse while waiting for the send time (R8)
    exp_time = '{40};
    load(0, 40);
    pulse_go();
    repeat (3) cyc();
    taken_i = 3'b010;
    cyc();
    taken_i = '0;
    chk(fault_o == 1'b1, "R8", fault_o, 1);
    pulse_go();

    // missing answer (R9)
    ack_limit_i = 8'd4;
    exp_time = '{0};
    load(2, 0);
    pulse_go();
    run(1000, 0, 100);
    chk(fault_o == 1'b1, "R9", fault_o, 1);
    chk(last_high == 4, "R9", last_high, 4);
    pulse_go();
    chk(!fault_o && ld_ready_o, "R11", fault_o, 0);

    repeat (2) cyc();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule